// File: doc/BRIEF.md
# Shared Attention and Data-Ready Interrupt Line

This block drives one level-type host interrupt wire that two causes share. The first cause is data ready: the transfer controller sends a one-cycle pulse each time it marks its output buffer full. The second cause is system-management attention: the back end asks for the attention status bit to be set, either with an interrupt or without one, or asks for it to be cleared. The block keeps one pending flag per cause. Each flag is cleared by its own kind of host read. A read of the data address clears the data-ready flag. A read of the status address clears the attention flag. The wire stays high while either flag is pending.

A new pending flag can only be raised when two conditions hold: the static input that says an interrupt wire is fitted, and the software enable bit. Flags that are already pending survive when the enable bit is dropped. The attention status bit goes to the status register of the surrounding interface. Register decoding and the transfer state machine are outside this block.

Top module: `shared_irq_ctrl`

## Requirements
- R1: After synchronous reset, irq_line is 0, attn_bit is 0 and no flag is pending.
- R2: A data_ready_pulse with line_present=1 and irq_enable=1 raises the data-ready flag, so irq_line is 1 after that clock edge.
- R3: A data_ready_pulse while line_present=0 or irq_enable=0 is ignored: irq_line stays 0.
- R4: host_rd_data clears the data-ready flag. irq_line falls when the attention flag is also clear.
- R5: host_rd_status clears the attention flag and leaves attn_bit unchanged.
- R6: attn_set_req always sets attn_bit. It raises the attention flag only if attn_with_irq=1, line_present=1 and irq_enable=1.
- R7: attn_clr_req clears both attn_bit and the attention flag.
- R8: irq_line stays 1 as long as either flag is pending. Clearing one flag leaves it high while the other flag remains pending.
- R9: Setting irq_enable to 0 does not clear flags that are already pending. It only blocks new ones.
- R10: When a set and a clear for the same flag arrive in the same cycle, the outcome is as follows. A data_ready_pulse wins over host_rd_data. attn_set_req with interrupt wins over host_rd_status. attn_clr_req wins over attn_set_req.
- R11: irq_line is registered. It changes on the first clock edge after the causing input and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_present | input | 1 | Static: an interrupt wire is fitted |
| irq_enable | input | 1 | Software interrupt enable |
| data_ready_pulse | input | 1 | One-cycle pulse: output buffer became full |
| attn_set_req | input | 1 | Back-end request to set attention |
| attn_with_irq | input | 1 | Qualifies attn_set_req: also request an interrupt |
| attn_clr_req | input | 1 | Back-end request to clear attention |
| host_rd_data | input | 1 | Host read strobe of the data address |
| host_rd_status | input | 1 | Host read strobe of the status address |
| irq_line | output | 1 | Shared level interrupt to the host |
| attn_bit | output | 1 | Attention bit for the status register |

## Verification
The pending flags are not visible at the ports. A flag that sticks or is lost therefore shows up only as irq_line staying high after the read that should have cleared it, or falling while the other cause is still pending. The bench arranges both causes to overlap so that either fault appears at the next clock edge. The reference model is compared on every clock, so a divergence is caught within one cycle of the event that caused it.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic [0:0] {
        SRC_DATA = 1'b0,
        SRC_ATTN = 1'b1
    } irq_src_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    function automatic logic may_raise(input logic present, input logic enable);
        return present & enable;
    endfunction

endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag
    import shared_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      present,
    input  logic      enable,
    input  flag_evt_t evt,
    output logic      flag_q,
    output logic      flag_d
);
    logic set_ok;

    assign set_ok = evt.set & may_raise(present, enable);

    always_comb begin
        flag_d = flag_q;
        if (evt.clr) flag_d = 1'b0;
        if (set_ok)  flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (evt.clr && !evt.set) |=> !flag_q); // R4

    AST_NO_UNGATED_SET: assert property (@(posedge clk) disable iff (rst)
        (!present || !enable) |=> !$rose(flag_q)); // R3

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !evt.clr) |=> flag_q); // R9

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
    import shared_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_next,
    output logic               irq_line
);
    always_ff @(posedge clk) begin
        if (rst) irq_line <= 1'b0;
        else     irq_line <= |pend_next;
    end
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
    import shared_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_present,
    input  logic irq_enable,
    input  logic data_ready_pulse,
    input  logic attn_set_req,
    input  logic attn_with_irq,
    input  logic attn_clr_req,
    input  logic host_rd_data,
    input  logic host_rd_status,
    output logic irq_line,
    output logic attn_bit
);
    flag_evt_t          evt [NUM_SRC];
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_d;

    // Attention set loses to a simultaneous clear request.
    always_comb begin
        evt[SRC_DATA].set = data_ready_pulse;
        evt[SRC_DATA].clr = host_rd_data;
        evt[SRC_ATTN].set = attn_set_req & attn_with_irq & ~attn_clr_req;
        evt[SRC_ATTN].clr = host_rd_status | attn_clr_req;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_pend_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .present (line_present),
            .enable  (irq_enable),
            .evt     (evt[s]),
            .flag_q  (pend_q[s]),
            .flag_d  (pend_d[s])
        );
    end

    irq_line_drv u_line (
        .clk       (clk),
        .rst       (rst),
        .pend_next (pend_d),
        .irq_line  (irq_line)
    );

    always_ff @(posedge clk) begin
        if (rst)               attn_bit <= 1'b0;
        else if (attn_clr_req) attn_bit <= 1'b0;
        else if (attn_set_req) attn_bit <= 1'b1;
    end

    AST_LINE_IS_OR: assert property (@(posedge clk) disable iff (rst)
        irq_line == (|pend_q)); // R8

    AST_ATTN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        attn_clr_req |=> (!attn_bit && !pend_q[SRC_ATTN])); // R7

    AST_ATTN_SET: assert property (@(posedge clk) disable iff (rst)
        (attn_set_req && !attn_clr_req) |=> attn_bit); // R6

    AST_STATUS_READ_KEEPS_BIT: assert property (@(posedge clk) disable iff (rst)
        (host_rd_status && !attn_set_req && !attn_clr_req) |=> $stable(attn_bit)); // R5

endmodule

// File: tb/test_shared_irq_ctrl.sv
module test_shared_irq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_present = 1'b1, irq_enable = 1'b1;
    logic data_ready_pulse = 0, attn_set_req = 0, attn_with_irq = 0, attn_clr_req = 0;
    logic host_rd_data = 0, host_rd_status = 0;
    logic irq_line, attn_bit;

    int errors = 0;
    int checks = 0;

    // behavioural reference
    bit m_data, m_attn, m_bit, m_line;

    always #4 clk = ~clk;

    shared_irq_ctrl i_shared_irq_ctrl (
        .clk(clk), .rst(rst), .line_present(line_present), .irq_enable(irq_enable),
        .data_ready_pulse(data_ready_pulse), .attn_set_req(attn_set_req),
        .attn_with_irq(attn_with_irq), .attn_clr_req(attn_clr_req),
        .host_rd_data(host_rd_data), .host_rd_status(host_rd_status),
        .irq_line(irq_line), .attn_bit(attn_bit)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_data = 0; m_attn = 0; m_bit = 0; m_line = 0;
        end else begin
            bit gate;
            gate = line_present && irq_enable;
            if (host_rd_data) m_data = 0;
            if (data_ready_pulse && gate) m_data = 1;
            if (host_rd_status) m_attn = 0;
            if (attn_clr_req) begin
                m_attn = 0; m_bit = 0;
            end else if (attn_set_req) begin
                m_bit = 1;
                if (attn_with_irq && gate) m_attn = 1;
            end
            m_line = m_data || m_attn;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 model line", irq_line, m_line);
            chk("R6 model attn_bit", attn_bit, m_bit);
        end
    end

    task automatic pulse(input bit d, input bit s, input bit c, input bit w,
                         input bit rdd, input bit rds);
        data_ready_pulse = d; attn_set_req = s; attn_clr_req = c; attn_with_irq = w;
        host_rd_data = rdd; host_rd_status = rds;
        @(negedge clk);
        data_ready_pulse = 0; attn_set_req = 0; attn_clr_req = 0; attn_with_irq = 0;
        host_rd_data = 0; host_rd_status = 0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 line after reset", irq_line, 1'b0);
        chk("R1 attn after reset", attn_bit, 1'b0);

        // R11: input set, line unchanged before the edge
        data_ready_pulse = 1;
        #2 chk("R11 no same-cycle change", irq_line, 1'b0);
        @(negedge clk); data_ready_pulse = 0;
        chk("R2 data ready raises line", irq_line, 1'b1);
        pulse(0,0,0,0,1,0);
        chk("R4 data read drops line", irq_line, 1'b0);

        irq_enable = 0;
        pulse(1,0,0,0,0,0);
        chk("R3 disabled ignored", irq_line, 1'b0);
        irq_enable = 1; line_present = 0;
        pulse(1,0,0,0,0,0);
        chk("R3 absent ignored", irq_line, 1'b0);
        pulse(0,1,0,1,0,0);
        chk("R6 absent line no attn irq", irq_line, 1'b0);
        chk("R6 bit set anyway", attn_bit, 1'b1);
        pulse(0,0,1,0,0,0);
        line_present = 1;

        pulse(0,1,0,0,0,0);
        chk("R6 set without irq bit", attn_bit, 1'b1);
        chk("R6 set without irq line", irq_line, 1'b0);
        pulse(0,0,0,0,0,1);
        chk("R5 status read keeps bit", attn_bit, 1'b1);
        pulse(0,0,1,0,0,0);
        chk("R7 clear bit", attn_bit, 1'b0);

        pulse(0,1,0,1,0,0);
        chk("R6 set with irq line", irq_line, 1'b1);
        pulse(1,0,0,0,0,0);
        pulse(0,0,0,0,1,0);
        chk("R8 line held by attention", irq_line, 1'b1);
        pulse(0,0,0,0,0,1);
        chk("R5 status read drops line", irq_line, 1'b0);
        chk("R5 bit unchanged", attn_bit, 1'b1);
        pulse(0,1,0,1,0,0);
        chk("R6 re-raise", irq_line, 1'b1);
        pulse(0,0,1,0,0,0);
        chk("R7 clear drops line", irq_line, 1'b0);
        chk("R7 clear drops bit", attn_bit, 1'b0);

        pulse(1,0,0,0,0,0);
        irq_enable = 0;
        repeat (2) @(negedge clk);
        chk("R9 pending kept when disabled", irq_line, 1'b1);
        pulse(0,0,0,0,1,0);
        chk("R9 read still clears", irq_line, 1'b0);
        irq_enable = 1;

        pulse(1,0,0,0,1,0);
        chk("R10 data set beats read", irq_line, 1'b1);
        pulse(0,0,0,0,1,0);
        pulse(0,1,1,1,0,0);
        chk("R10 attn clear beats set line", irq_line, 1'b0);
        chk("R10 attn clear beats set bit", attn_bit, 1'b0);
        pulse(0,1,0,1,0,1);
        chk("R10 attn set beats status read", irq_line, 1'b1);
        pulse(0,0,1,0,0,0);
        chk("R7 final clear", irq_line, 1'b0);

        rst = 1; pulse(1,1,0,1,0,0); rst = 0;
        chk("R1 reset clears all line", irq_line, 1'b0);
        chk("R1 reset clears all bit", attn_bit, 1'b0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule